// File: doc/BRIEF.md
# Chained Serial Sample Frame Shifter

This block serialises one sample frame onto a single output line when an external serial master clocks it. A frame starts with a 24-bit status header supplied in parallel by the surrounding logic. One word per channel follows the header, channel 0 first, and every field leaves most significant bit first. The word width is 24 bits in the high-resolution setting and 16 bits in the low-resolution setting. A frame is captured from the parallel inputs on a data-valid strobe. If the strobe arrives while a read is under way, the sample is parked and handed over once chip select returns high.

Several devices can share one output in two ways. In standard mode each device drives its output only while its own chip select is low, and bits clocked past the end of the frame read as zeros. In chained mode the block forwards the serial stream of a downstream device. Each bit sampled on the upstream input at a serial clock rising edge reappears on the output exactly one frame length later, so a whole chain can be read through the output of the first device.

The serial clock, chip select and upstream input are treated as slow signals that are synchronous to the block clock. Rising edges of the serial clock are detected with the block clock.

Top module: `dchain_frame_shifter`

## Requirements
- R1: While reset is applied, and after it is released with no frame loaded, `dout` is 0.
- R2: `dout_oe` is 1 exactly while `cs_n` is 0, so the output may be tri-stated whenever the device is deselected.
- R3: In 24-bit mode a frame is NUM_CH*24+24 bits long: `status_hdr` bits 23..0, then channel 0 bits 23..0 taken from `ch_data[23:0]`, then channel 1 taken from `ch_data[47:24]`, and so on up to the last channel.
- R4: `dout` changes only on the clock edge at which a serial clock rising edge is detected while `cs_n` is 0. The first such edge after a load presents the first frame bit, and each later edge presents the next bit.
- R5: In 16-bit mode (`cfg_short`=1) a frame is NUM_CH*16+24 bits long, and each channel contributes only bits 15..0 of its 24-bit slot in `ch_data`.
- R6: In chained mode (`cfg_chain`=1), the bit on `daisy_in` at serial clock rising edge k is driven on `dout` at rising edge k+L, where L is the length of the loaded frame.
- R7: In standard mode (`cfg_chain`=0), every bit clocked out beyond the end of the frame is 0.
- R8: A `data_valid` strobe seen while `cs_n` is 1 loads the frame on that same clock edge and returns `dout` to 0.
- R9: A `data_valid` strobe seen while `cs_n` is 0 does not disturb the frame being read. The sample is kept, with a later strobe replacing an earlier one, and is loaded on the first clock edge at which `cs_n` is 1.
- R10: The word width is taken from `cfg_short` at the strobe that captures the sample. `cfg_chain` is applied at each serial clock rising edge as it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chain | input | 1 | 1 = forward `daisy_in` after the frame, 0 = fill with zeros |
| cfg_short | input | 1 | 1 = 16-bit channel words, 0 = 24-bit channel words |
| status_hdr | input | HDR_W (24) | Parallel header word |
| ch_data | input | NUM_CH*RES_HI (96) | Channel samples, channel i in bits [24i+23:24i] |
| data_valid | input | 1 | One-cycle strobe: a new sample is present |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| daisy_in | input | 1 | Serial data from the downstream device |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for the serial data pad |

## Verification
A serial clock rising edge that the bench raises before clock edge t updates `dout` at edge t. A strobe updates `dout` at its own edge. A parked sample is loaded at the first edge that sees `cs_n` high. The queue model in the bench moves its expected bit just after each of those edges and compares 5 ns after every rising clock edge. This keeps every comparison clear of both the updating edge and the bench's input changes on the falling edge. The serial clock is held for two block cycles in each phase, so each bit is stable through several comparisons and any early or late shift shows up as a mismatch.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  function automatic int unsigned frame_bits(input int unsigned nch,
                                             input int unsigned res,
                                             input int unsigned hdr);
    return nch * res + hdr;
  endfunction
endpackage

// File: rtl/dchain_rst_sync.sv
module dchain_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/dchain_packer.sv
module dchain_packer #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES_HI = 24,
  parameter int unsigned RES_LO = 16,
  parameter int unsigned HDR_W  = 24
) (
  input  logic                       short_mode,
  input  logic [HDR_W-1:0]           hdr,
  input  logic [NUM_CH*RES_HI-1:0]   ch_data,
  output logic [dchain_pkg::frame_bits(NUM_CH, RES_HI, HDR_W)-1:0] frame
);
  localparam int unsigned LEN_HI = dchain_pkg::frame_bits(NUM_CH, RES_HI, HDR_W);
  localparam int unsigned LEN_LO = dchain_pkg::frame_bits(NUM_CH, RES_LO, HDR_W);

  logic [LEN_HI-1:0] long_w;
  logic [LEN_LO-1:0] short_w;

  assign long_w[LEN_HI-1 -: HDR_W]  = hdr;
  assign short_w[LEN_LO-1 -: HDR_W] = hdr;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign long_w[LEN_HI-HDR_W-1-i*RES_HI -: RES_HI] = ch_data[i*RES_HI +: RES_HI];
    assign short_w[LEN_LO-HDR_W-1-i*RES_LO -: RES_LO] = ch_data[i*RES_HI +: RES_LO];
  end

  // short frames sit right-aligned so the output tap alone selects the length
  assign frame = short_mode ? {{(LEN_HI-LEN_LO){1'b0}}, short_w} : long_w;
endmodule

// File: rtl/dchain_stager.sv
module dchain_stager #(
  parameter int unsigned LEN_HI = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_valid,
  input  logic              cs_n,
  input  logic [LEN_HI-1:0] packed_in,
  input  logic              short_in,
  output logic              load,
  output logic [LEN_HI-1:0] load_frame,
  output logic              load_short
);
  logic [LEN_HI-1:0] hold_q, hold_d;
  logic              hshort_q, hshort_d;
  logic              pend_q, pend_d;
  logic              hold_en;

  always_comb begin
    load       = 1'b0;
    load_frame = hold_q;
    load_short = hshort_q;
    if (data_valid && cs_n) begin
      load       = 1'b1;
      load_frame = packed_in;
      load_short = short_in;
    end else if (pend_q && cs_n) begin
      load = 1'b1;
    end
  end

  always_comb begin
    hold_en  = data_valid && !cs_n;
    hold_d   = hold_en ? packed_in : hold_q;
    hshort_d = hold_en ? short_in  : hshort_q;
    if (hold_en)   pend_d = 1'b1;
    else if (load) pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hshort_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      hold_q   <= hold_d;
      hshort_q <= hshort_d;
      pend_q   <= pend_d;
    end
  end
endmodule

// File: rtl/dchain_shifter.sv
module dchain_shifter #(
  parameter int unsigned LEN_HI = 120,
  parameter int unsigned LEN_LO = 88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_HI-1:0] load_frame,
  input  logic              load_short,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              daisy_in,
  input  logic              cfg_chain,
  output logic              dout
);
  logic [LEN_HI-1:0] sr_q, sr_d;
  logic              short_q, short_d;
  logic              dout_q, dout_d;
  logic              sclk_q;
  logic              rise;
  logic              tap;

  assign rise = sclk && !sclk_q && !cs_n;
  assign tap  = short_q ? sr_q[LEN_LO-1] : sr_q[LEN_HI-1];

  always_comb begin
    sr_d    = sr_q;
    short_d = short_q;
    dout_d  = dout_q;
    if (load) begin
      sr_d    = load_frame;
      short_d = load_short;
      dout_d  = 1'b0;
    end else if (rise) begin
      dout_d = tap;
      sr_d   = {sr_q[LEN_HI-2:0], cfg_chain & daisy_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      short_q <= 1'b0;
      dout_q  <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      short_q <= short_d;
      dout_q  <= dout_d;
      sclk_q  <= sclk;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/dchain_frame_shifter.sv
module dchain_frame_shifter #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES_HI = 24,
  parameter int unsigned RES_LO = 16,
  parameter int unsigned HDR_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_chain,
  input  logic                     cfg_short,
  input  logic [HDR_W-1:0]         status_hdr,
  input  logic [NUM_CH*RES_HI-1:0] ch_data,
  input  logic                     data_valid,
  input  logic                     sclk,
  input  logic                     cs_n,
  input  logic                     daisy_in,
  output logic                     dout,
  output logic                     dout_oe
);
  localparam int unsigned LEN_HI = dchain_pkg::frame_bits(NUM_CH, RES_HI, HDR_W);
  localparam int unsigned LEN_LO = dchain_pkg::frame_bits(NUM_CH, RES_LO, HDR_W);

  logic              rst_sn;
  logic [LEN_HI-1:0] packed_w;
  logic              stage_load;
  logic [LEN_HI-1:0] stage_frame;
  logic              stage_short;

  dchain_rst_sync rst_sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  dchain_packer #(
    .NUM_CH (NUM_CH),
    .RES_HI (RES_HI),
    .RES_LO (RES_LO),
    .HDR_W  (HDR_W)
  ) packer_i (
    .short_mode (cfg_short),
    .hdr        (status_hdr),
    .ch_data    (ch_data),
    .frame      (packed_w)
  );

  dchain_stager #(.LEN_HI(LEN_HI)) stager_i (
    .clk        (clk),
    .rst_n      (rst_sn),
    .data_valid (data_valid),
    .cs_n       (cs_n),
    .packed_in  (packed_w),
    .short_in   (cfg_short),
    .load       (stage_load),
    .load_frame (stage_frame),
    .load_short (stage_short)
  );

  dchain_shifter #(.LEN_HI(LEN_HI), .LEN_LO(LEN_LO)) shifter_i (
    .clk        (clk),
    .rst_n      (rst_sn),
    .load       (stage_load),
    .load_frame (stage_frame),
    .load_short (stage_short),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .daisy_in   (daisy_in),
    .cfg_chain  (cfg_chain),
    .dout       (dout)
  );

  assign dout_oe = !cs_n;
endmodule

// File: rtl/dchain_frame_shifter_chk.sv
module dchain_frame_shifter_chk #(
  parameter int unsigned LEN_HI = 120,
  parameter int unsigned LEN_LO = 88
) (
  input logic clk,
  input logic rst_sn,
  input logic cs_n,
  input logic sclk,
  input logic data_valid,
  input logic cfg_chain,
  input logic load,
  input logic load_short,
  input logic dout
);
  logic        sclk_d;
  logic        rise_c;
  logic [15:0] cnt_q;
  logic [15:0] len_q;
  logic        chain_seen_q;
  logic        park_q;

  assign rise_c = sclk && !sclk_d && !cs_n;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sclk_d       <= 1'b0;
      cnt_q        <= '0;
      len_q        <= '0;
      chain_seen_q <= 1'b0;
      park_q       <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (load) begin
        cnt_q        <= '0;
        len_q        <= load_short ? 16'(LEN_LO) : 16'(LEN_HI);
        chain_seen_q <= 1'b0;
      end else if (rise_c) begin
        if (cnt_q != 16'hFFFF) cnt_q <= cnt_q + 16'd1;
        if (cfg_chain) chain_seen_q <= 1'b1;
      end
      if (data_valid && !cs_n) park_q <= 1'b1;
      else if (load)           park_q <= 1'b0;
    end
  end

  // R4: outside a detected rising edge the serial output holds during a read
  p_hold_between_edges_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cs_n && !rise_c) |=> $stable(dout));

  // R7: standard-mode fill beyond the frame end is zero
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (rise_c && (cnt_q >= len_q) && !chain_seen_q && !cfg_chain) |=> !dout);

  // R9: no load takes place while a read is in progress
  p_no_load_mid_read_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !cs_n |-> !load);

  // R9: a parked sample is loaded as soon as chip select is high
  p_parked_loads_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (park_q && cs_n) |-> load);

  // R8: a load returns the output to zero
  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    load |=> !dout);
endmodule

bind dchain_frame_shifter dchain_frame_shifter_chk #(
  .LEN_HI (LEN_HI),
  .LEN_LO (LEN_LO)
) chk_i (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .data_valid (data_valid),
  .cfg_chain  (cfg_chain),
  .load       (stage_load),
  .load_short (stage_short),
  .dout       (dout)
);

// File: tb/dchain_frame_shifter_tb_top.sv
module dchain_frame_shifter_tb_top;
  localparam int NUM_CH = 4;
  localparam int RES_HI = 24;
  localparam int RES_LO = 16;
  localparam int HDR_W  = 24;
  localparam int LEN_HI = NUM_CH * RES_HI + HDR_W;
  localparam int LEN_LO = NUM_CH * RES_LO + HDR_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                     rst_n;
  logic                     cfg_chain, cfg_short;
  logic [HDR_W-1:0]         status_hdr;
  logic [NUM_CH*RES_HI-1:0] ch_data;
  logic                     data_valid, sclk, cs_n, daisy_in;
  logic                     dout, dout_oe;

  dchain_frame_shifter #(
    .NUM_CH (NUM_CH), .RES_HI (RES_HI), .RES_LO (RES_LO), .HDR_W (HDR_W)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_chain (cfg_chain), .cfg_short (cfg_short),
    .status_hdr (status_hdr), .ch_data (ch_data), .data_valid (data_valid),
    .sclk (sclk), .cs_n (cs_n), .daisy_in (daisy_in),
    .dout (dout), .dout_oe (dout_oe)
  );

  bit    q[$];
  bit    stage_q[$];
  bit    pend_q[$];
  bit    pend_v;
  logic  exp_dout;
  string tag;
  int    tests, fails;
  bit    run;

  function void build_frame(input bit shrt);
    int res;
    res = shrt ? RES_LO : RES_HI;
    stage_q.delete();
    for (int b = HDR_W - 1; b >= 0; b--) stage_q.push_back(status_hdr[b]);
    for (int c = 0; c < NUM_CH; c++)
      for (int b = res - 1; b >= 0; b--) stage_q.push_back(ch_data[c*RES_HI + b]);
  endfunction

  task automatic check(input string t, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  // per-clock comparison against the queue model
  always @(posedge clk) begin
    if (run) begin
      #5;
      tests++;
      if (dout !== exp_dout || dout_oe !== !cs_n) begin
        fails++;
        $display("FAIL %s: dout=%0b expected=%0b dout_oe=%0b expected=%0b",
                 tag, dout, exp_dout, dout_oe, !cs_n);
      end
    end
  end

  task automatic strobe();
    @(negedge clk);
    status_hdr = HDR_W'($urandom);
    for (int c = 0; c < NUM_CH; c++) ch_data[c*RES_HI +: RES_HI] = RES_HI'($urandom);
    data_valid = 1'b1;
    build_frame(cfg_short);
    @(posedge clk);
    #1;
    data_valid = 1'b0;
    if (cs_n) begin
      q = stage_q; exp_dout = 1'b0; pend_v = 1'b0;
    end else begin
      pend_q = stage_q; pend_v = 1'b1;
    end
  endtask

  task automatic select();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic deselect();
    @(negedge clk);
    cs_n = 1'b1;
    @(posedge clk);
    #1;
    if (pend_v) begin
      q = pend_q; exp_dout = 1'b0; pend_v = 1'b0;
    end
  endtask

  task automatic pulse(input bit d);
    @(negedge clk);
    sclk = 1'b1;
    daisy_in = d;
    @(posedge clk);
    #1;
    q.push_back(cfg_chain ? d : 1'b0);
    exp_dout = q.pop_front();
    @(negedge clk);
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_bits(input int n);
    for (int i = 0; i < n; i++) pulse(1'($urandom));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    tests = 0; fails = 0; run = 0; pend_v = 0;
    rst_n = 1'b0; cfg_chain = 1'b0; cfg_short = 1'b0; status_hdr = '0;
    ch_data = '0; data_valid = 1'b0; sclk = 1'b0; cs_n = 1'b1; daisy_in = 1'b0;
    exp_dout = 1'b0; tag = "R1";
    repeat (3) @(negedge clk);
    check("R1 dout in reset", dout, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 dout after reset", dout, 1'b0);
    check("R2 oe deselected", dout_oe, 1'b0);
    run = 1;

    tag = "R2";
    select();
    #1 check("R2 oe selected", dout_oe, 1'b1);
    deselect();

    tag = "R3 R4 R7 R8";
    strobe();
    select();
    read_bits(LEN_HI + 8);
    deselect();

    tag = "R3 R6 R8";
    cfg_chain = 1'b1;
    strobe();
    select();
    read_bits(LEN_HI + 24);
    deselect();

    tag = "R5 R6";
    cfg_short = 1'b1;
    strobe();
    select();
    read_bits(LEN_LO + 12);
    deselect();

    tag = "R5 R7";
    cfg_chain = 1'b0;
    strobe();
    select();
    read_bits(LEN_LO + 6);
    deselect();

    tag = "R9 R10";
    cfg_short = 1'b0; cfg_chain = 1'b1;
    strobe();
    select();
    read_bits(10);
    strobe();
    read_bits(5);
    cfg_short = 1'b1;
    strobe();
    cfg_short = 1'b0;
    read_bits(5);
    deselect();
    tag = "R9 R10 parked";
    select();
    read_bits(LEN_LO + 4);
    deselect();

    tag = "R10 live chain";
    cfg_short = 1'b0; cfg_chain = 1'b0;
    strobe();
    select();
    read_bits(LEN_HI / 2);
    cfg_chain = 1'b1;
    read_bits(LEN_HI);
    cfg_chain = 1'b0;
    read_bits(LEN_HI / 2 + 8);
    deselect();

    repeat (4) @(negedge clk);
    run = 0;
    summary();
    $finish;
  end
endmodule